// File: doc/BRIEF.md
# In-Place Overlay Tile Skip Controller

This block walks a pixel pipeline across a frame cut into square tiles of 8x8 pixels, taken in raster order. For each tile it decides whether the pipeline has any work to do. It then either issues a three-step command burst for that tile (fetch, process, write back) or steps past the tile in a single idle cycle. A skipped tile causes no memory traffic.

When in-place rendering is on, only tiles that touch at least one enabled overlay rectangle are worked on. The write-back goes to the same address the tile was fetched from, and the output buffer base is not used. In-place operation needs an RGB source, and the output format must match the source format. A start request with any other combination is refused and raises a configuration-error flag. With in-place rendering off, every tile is worked on, the overlays play no part, and write-back goes to the output buffer.

Configuration inputs must stay steady from the start request until the done pulse. The block has no command handshake. One command is presented per cycle, and the downstream pipeline must take it in that cycle.

Top module: `tile_skip_ctrl`

## Requirements
- R1: With in-place on, a tile that touches no enabled rectangle takes exactly one cycle and drives no command. A tile that touches one gets a command burst. With no rectangle enabled, the whole frame is stepped through silently and done still follows.
- R2: Tiles are 8x8 pixels, visited with x fastest then y. There are ceil(width/8) tiles per row and ceil(height/8) rows. A tile (tx,ty) touches a rectangle when 8*tx <= x1, 8*tx+7 >= x0, 8*ty <= y1 and 8*ty+7 >= y0, with bounds inclusive. A rectangle whose enable bit is 0 is ignored.
- R3: Each tile first spends one decision cycle with no command. A worked tile then shows op FETCH (code 0), then PROC (code 1), then WB (code 2), in three consecutive cycles with cmd_valid high. cmd_tile_x and cmd_tile_y hold the tile indices.
- R4: FETCH and PROC carry the address src_base + 4*(8*ty*width + 8*tx). In in-place mode WB carries that same address, whatever out_base holds.
- R5: With in-place off, every tile is worked on, overlays have no effect, and WB carries out_base + 4*(8*ty*width + 8*tx).
- R6: Format codes with bit 2 set are YUV, and codes 0 to 3 are RGB. A start request in in-place mode with a YUV source format is refused: cfg_err rises, and no command and no done follow.
- R7: A start request in in-place mode with out_fmt different from src_fmt is refused in the same way. A start request with width or height equal to zero is refused in either mode.
- R8: cfg_err is updated only when a start request is accepted for evaluation while the block is idle. It is set if the configuration is invalid and cleared if valid, and it holds its value otherwise.
- R9: done is high for exactly one cycle, namely the cycle after the last tile's final cycle. A start request while a frame is running is ignored.
- R10: During and straight after reset there is no command, no done and cfg_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-frame request pulse |
| inplace_en_i | input | 1 | In-place rendering enable |
| frame_w_i | input | 12 | Frame width in pixels |
| frame_h_i | input | 12 | Frame height in pixels |
| src_fmt_i | input | 3 | Source pixel format code, bit 2 = YUV |
| out_fmt_i | input | 3 | Output pixel format code |
| src_base_i | input | 32 | Source buffer byte address |
| out_base_i | input | 32 | Output buffer byte address |
| ovl_en_i | input | 4 | Per-rectangle enable |
| ovl_x0_i | input | 48 | Left bounds, 12 bits per rectangle |
| ovl_y0_i | input | 48 | Top bounds, 12 bits per rectangle |
| ovl_x1_i | input | 48 | Right bounds (inclusive) |
| ovl_y1_i | input | 48 | Bottom bounds (inclusive) |
| cmd_valid_o | output | 1 | Command present this cycle |
| cmd_op_o | output | 2 | 0 fetch, 1 process, 2 write back |
| cmd_addr_o | output | 32 | Tile byte address for the command, 0 when idle |
| cmd_tile_x_o | output | 10 | Tile column of the command |
| cmd_tile_y_o | output | 10 | Tile row of the command |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| cfg_err_o | output | 1 | Configuration refused at last start request |

## Verification
A start request sampled at one edge puts the decision cycle of tile (0,0) in the next cycle, and cfg_err follows at that same edge. A worked tile's FETCH appears one cycle after its decision cycle, and PROC and WB follow in the two cycles after that. done rises in the cycle after the last decision or WB cycle. The bench model turns each accepted start into a queue holding one expected entry per cycle, pops one entry at each rising edge, and compares every output against the front entry on the falling edge. Each result is therefore checked in the exact cycle it is due, and never one cycle early or late.

// File: rtl/tile_skip_pkg.sv
package tile_skip_pkg;

   typedef enum logic [1:0] {
      OP_FETCH = 2'd0,
      OP_PROC  = 2'd1,
      OP_WB    = 2'd2
   } tile_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SCAN  = 3'd1,
      ST_FETCH = 3'd2,
      ST_PROC  = 3'd3,
      ST_WB    = 3'd4
   } seq_state_e;

endpackage

// File: rtl/ovl_rect_hit.sv
module ovl_rect_hit #(
   parameter int CW = 12,
   parameter int TW = 3
) (
   input  logic [CW:0]   tile_px_i,
   input  logic [CW:0]   tile_py_i,
   input  logic          en_i,
   input  logic [CW-1:0] x0_i,
   input  logic [CW-1:0] y0_i,
   input  logic [CW-1:0] x1_i,
   input  logic [CW-1:0] y1_i,
   output logic          hit_o
);
   localparam logic [CW:0] SPAN = (CW+1)'((1 << TW) - 1);

   logic [CW:0] px_end, py_end;
   logic        ovx, ovy;

   always_comb begin
      px_end = tile_px_i + SPAN;
      py_end = tile_py_i + SPAN;
      ovx    = (tile_px_i <= {1'b0, x1_i}) && (px_end >= {1'b0, x0_i});
      ovy    = (tile_py_i <= {1'b0, y1_i}) && (py_end >= {1'b0, y0_i});
      hit_o  = en_i && ovx && ovy;
   end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
   parameter int CW       = 12,
   parameter int TW       = 3,
   parameter int AW       = 32,
   parameter int BPP_LOG2 = 2,
   localparam int TIW     = CW - TW + 1
) (
   input  logic [AW-1:0]  base_i,
   input  logic [CW-1:0]  frame_w_i,
   input  logic [TIW-1:0] tx_i,
   input  logic [TIW-1:0] ty_i,
   output logic [AW-1:0]  addr_o
);
   logic [AW-1:0] row_px, pix_off;

   always_comb begin
      row_px  = AW'(ty_i) * AW'(frame_w_i);
      pix_off = (row_px << TW) + (AW'(tx_i) << TW);
      addr_o  = base_i + (pix_off << BPP_LOG2);
   end
endmodule

// File: rtl/tile_seq.sv
module tile_seq
   import tile_skip_pkg::*;
#(
   parameter int CW   = 12,
   parameter int TW   = 3,
   localparam int TIW = CW - TW + 1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           start_i,
   input  logic           cfg_ok_i,
   input  logic           hit_i,
   input  logic [TIW-1:0] n_tx_i,
   input  logic [TIW-1:0] n_ty_i,
   output seq_state_e     state_o,
   output logic [TIW-1:0] tx_o,
   output logic [TIW-1:0] ty_o,
   output logic           done_o,
   output logic           err_o
);
   seq_state_e     state_q;
   logic [TIW-1:0] tx_q, ty_q;
   logic           done_q, err_q;
   logic           last_x, last_y, step;

   assign last_x = (tx_q == n_tx_i - 1'b1);
   assign last_y = (ty_q == n_ty_i - 1'b1);
   assign step   = (state_q == ST_WB) || (state_q == ST_SCAN && !hit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         tx_q    <= '0;
         ty_q    <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  err_q <= !cfg_ok_i;
                  if (cfg_ok_i) begin
                     tx_q    <= '0;
                     ty_q    <= '0;
                     state_q <= ST_SCAN;
                  end
               end
            end
            ST_SCAN:  if (hit_i) state_q <= ST_FETCH;
            ST_FETCH: state_q <= ST_PROC;
            ST_PROC:  state_q <= ST_WB;
            default:  ;
         endcase
         if (step) begin
            if (!last_x) begin
               tx_q    <= tx_q + 1'b1;
               state_q <= ST_SCAN;
            end else if (!last_y) begin
               tx_q    <= '0;
               ty_q    <= ty_q + 1'b1;
               state_q <= ST_SCAN;
            end else begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign state_o = state_q;
   assign tx_o    = tx_q;
   assign ty_o    = ty_q;
   assign done_o  = done_q;
   assign err_o   = err_q;

   assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);
   assert_done_at_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> state_q == ST_IDLE);
   assert_err_keeps_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |-> state_q == ST_IDLE);
   assert_err_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> $stable(err_q));
endmodule

// File: rtl/tile_skip_ctrl.sv
module tile_skip_ctrl
   import tile_skip_pkg::*;
#(
   parameter int CW       = 12,
   parameter int TW       = 3,
   parameter int AW       = 32,
   parameter int BPP_LOG2 = 2,
   parameter int NRECT    = 4,
   parameter int FW       = 3,
   localparam int TIW     = CW - TW + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             inplace_en_i,
   input  logic [CW-1:0]    frame_w_i,
   input  logic [CW-1:0]    frame_h_i,
   input  logic [FW-1:0]    src_fmt_i,
   input  logic [FW-1:0]    out_fmt_i,
   input  logic [AW-1:0]    src_base_i,
   input  logic [AW-1:0]    out_base_i,
   input  logic [NRECT-1:0] ovl_en_i,
   input  logic [NRECT*CW-1:0] ovl_x0_i,
   input  logic [NRECT*CW-1:0] ovl_y0_i,
   input  logic [NRECT*CW-1:0] ovl_x1_i,
   input  logic [NRECT*CW-1:0] ovl_y1_i,
   output logic             cmd_valid_o,
   output logic [1:0]       cmd_op_o,
   output logic [AW-1:0]    cmd_addr_o,
   output logic [TIW-1:0]   cmd_tile_x_o,
   output logic [TIW-1:0]   cmd_tile_y_o,
   output logic             done_o,
   output logic             cfg_err_o
);
   localparam int YUV_BIT = FW - 1;

   if (CW <= TW) begin : g_bad_tile
      $error("tile size must be smaller than the coordinate range");
   end
   if (NRECT < 1 || NRECT > 16) begin : g_bad_nrect
      $error("NRECT out of range");
   end
   if (FW < 2) begin : g_bad_fmt
      $error("format code needs at least two bits");
   end

   seq_state_e     state;
   logic [TIW-1:0] tx, ty, n_tx, n_ty;
   logic [CW:0]    w_round, h_round, tile_px, tile_py;
   logic [NRECT-1:0] rect_hit;
   logic           hit_any, cfg_ok, fmt_ok, use_out;
   logic [AW-1:0]  addr_base, tile_addr;
   logic           seq_done, seq_err;

   assign w_round = {1'b0, frame_w_i} + (CW+1)'((1 << TW) - 1);
   assign h_round = {1'b0, frame_h_i} + (CW+1)'((1 << TW) - 1);
   assign n_tx    = w_round[CW:TW];
   assign n_ty    = h_round[CW:TW];
   assign tile_px = {tx, {TW{1'b0}}};
   assign tile_py = {ty, {TW{1'b0}}};

   for (genvar r = 0; r < NRECT; r++) begin : g_rect
      ovl_rect_hit #(.CW(CW), .TW(TW)) i_hit (
         .tile_px_i (tile_px),
         .tile_py_i (tile_py),
         .en_i      (ovl_en_i[r]),
         .x0_i      (ovl_x0_i[r*CW +: CW]),
         .y0_i      (ovl_y0_i[r*CW +: CW]),
         .x1_i      (ovl_x1_i[r*CW +: CW]),
         .y1_i      (ovl_y1_i[r*CW +: CW]),
         .hit_o     (rect_hit[r])
      );
   end

   assign hit_any = inplace_en_i ? (|rect_hit) : 1'b1;
   assign fmt_ok  = !src_fmt_i[YUV_BIT] && (src_fmt_i == out_fmt_i);
   assign cfg_ok  = (frame_w_i != '0) && (frame_h_i != '0) &&
                    (!inplace_en_i || fmt_ok);

   tile_seq #(.CW(CW), .TW(TW)) i_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .cfg_ok_i (cfg_ok),
      .hit_i    (hit_any),
      .n_tx_i   (n_tx),
      .n_ty_i   (n_ty),
      .state_o  (state),
      .tx_o     (tx),
      .ty_o     (ty),
      .done_o   (seq_done),
      .err_o    (seq_err)
   );

   assign use_out   = (state == ST_WB) && !inplace_en_i;
   assign addr_base = use_out ? out_base_i : src_base_i;

   tile_addr_gen #(.CW(CW), .TW(TW), .AW(AW), .BPP_LOG2(BPP_LOG2)) i_addr (
      .base_i    (addr_base),
      .frame_w_i (frame_w_i),
      .tx_i      (tx),
      .ty_i      (ty),
      .addr_o    (tile_addr)
   );

   always_comb begin
      cmd_valid_o = 1'b0;
      cmd_op_o    = OP_FETCH;
      case (state)
         ST_FETCH: begin cmd_valid_o = 1'b1; cmd_op_o = OP_FETCH; end
         ST_PROC:  begin cmd_valid_o = 1'b1; cmd_op_o = OP_PROC;  end
         ST_WB:    begin cmd_valid_o = 1'b1; cmd_op_o = OP_WB;    end
         default:  ;
      endcase
      cmd_addr_o   = cmd_valid_o ? tile_addr : '0;
      cmd_tile_x_o = cmd_valid_o ? tx : '0;
      cmd_tile_y_o = cmd_valid_o ? ty : '0;
   end

   assign done_o    = seq_done;
   assign cfg_err_o = seq_err;

   assert_fetch_then_proc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o && cmd_op_o == OP_FETCH) |=> (cmd_valid_o && cmd_op_o == OP_PROC));
   assert_proc_then_wb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o && cmd_op_o == OP_PROC) |=> (cmd_valid_o && cmd_op_o == OP_WB));
   assert_skip_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_SCAN && !hit_any) |=> !cmd_valid_o);
   assert_err_no_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o |-> (!done_o && !cmd_valid_o));
endmodule

// File: tb/test_tile_skip_ctrl.sv
`timescale 1ns/1ps
module test_tile_skip_ctrl;
   localparam int CW = 12;
   localparam int TIW = 10;
   localparam int NR = 4;

   typedef struct packed {
      logic        v;
      logic [1:0]  op;
      logic [31:0] addr;
      logic [9:0]  tx;
      logic [9:0]  ty;
      logic        dn;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic inplace = 1'b0;
   logic [CW-1:0] fw = '0, fh = '0;
   logic [2:0] sfmt = '0, ofmt = '0;
   logic [31:0] sbase = '0, obase = '0;
   int r_en[NR], r_x0[NR], r_y0[NR], r_x1[NR], r_y1[NR];
   logic [NR-1:0] en_v;
   logic [NR*CW-1:0] x0_v, y0_v, x1_v, y1_v;

   logic cv, dn, ce;
   logic [1:0] op;
   logic [31:0] addr;
   logic [TIW-1:0] ctx, cty;

   exp_t q[$];
   logic m_err = 1'b0;
   int n_chk = 0, n_bad = 0, cyc = 0;
   string cur_req = "R10";

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NR; i++) begin
         en_v[i] = r_en[i] != 0;
         x0_v[i*CW +: CW] = CW'(r_x0[i]);
         y0_v[i*CW +: CW] = CW'(r_y0[i]);
         x1_v[i*CW +: CW] = CW'(r_x1[i]);
         y1_v[i*CW +: CW] = CW'(r_y1[i]);
      end
   end

   tile_skip_ctrl i_tile_skip_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .inplace_en_i(inplace),
      .frame_w_i(fw), .frame_h_i(fh), .src_fmt_i(sfmt), .out_fmt_i(ofmt),
      .src_base_i(sbase), .out_base_i(obase), .ovl_en_i(en_v),
      .ovl_x0_i(x0_v), .ovl_y0_i(y0_v), .ovl_x1_i(x1_v), .ovl_y1_i(y1_v),
      .cmd_valid_o(cv), .cmd_op_o(op), .cmd_addr_o(addr),
      .cmd_tile_x_o(ctx), .cmd_tile_y_o(cty), .done_o(dn), .cfg_err_o(ce)
   );

   function automatic bit tile_hit(int tx, int ty);
      for (int i = 0; i < NR; i++)
         if (r_en[i] != 0 && 8*tx <= r_x1[i] && 8*tx+7 >= r_x0[i] &&
             8*ty <= r_y1[i] && 8*ty+7 >= r_y0[i]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic exp_t mk(logic v, int o, longint a, int tx, int ty, logic d);
      exp_t e;
      e.v = v; e.op = 2'(o); e.addr = 32'(a); e.tx = 10'(tx); e.ty = 10'(ty); e.dn = d;
      return e;
   endfunction

   // Reference model: one queue entry per expected cycle after an accepted start.
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_err <= 1'b0;
      end else begin
         if (q.size() != 0) void'(q.pop_front());
         if (q.size() == 0 && start) begin
            bit ok;
            ok = fw != 0 && fh != 0 &&
                 (!inplace || (sfmt < 4 && sfmt == ofmt));
            m_err <= !ok;
            if (ok) begin
               int ntx, nty;
               ntx = (int'(fw) + 7) / 8;
               nty = (int'(fh) + 7) / 8;
               for (int ty = 0; ty < nty; ty++)
                  for (int tx = 0; tx < ntx; tx++) begin
                     longint off, sa, wa;
                     off = 4 * (8*ty*longint'(fw) + 8*tx);
                     sa = sbase + off;
                     wa = inplace ? sa : obase + off;
                     q.push_back(mk(0, 0, 0, 0, 0, 0));
                     if (!inplace || tile_hit(tx, ty)) begin
                        q.push_back(mk(1, 0, sa, tx, ty, 0));
                        q.push_back(mk(1, 1, sa, tx, ty, 0));
                        q.push_back(mk(1, 2, wa, tx, ty, 0));
                     end
                  end
               q.push_back(mk(0, 0, 0, 0, 0, 1));
            end
         end
      end
   end

   always @(negedge clk) begin
      exp_t e;
      exp_t a;
      string tag;
      e = (q.size() != 0) ? q[0] : mk(0, 0, 0, 0, 0, 0);
      a = '{v: cv, op: op, addr: addr, tx: ctx, ty: cty, dn: dn};
      tag = rst_n ? cur_req : "R10";
      n_chk++;
      if (a !== e || ce !== m_err) begin
         n_bad++;
         $display("FAIL %s cyc %0d: got v=%b op=%0d a=%h t=(%0d,%0d) dn=%b err=%b exp v=%b op=%0d a=%h t=(%0d,%0d) dn=%b err=%b",
                  tag, cyc, a.v, a.op, a.addr, a.tx, a.ty, a.dn, ce,
                  e.v, e.op, e.addr, e.tx, e.ty, e.dn, m_err);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: got running, exp finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic set_rect(int i, int en, int x0, int y0, int x1, int y1);
      r_en[i] = en; r_x0[i] = x0; r_y0[i] = y0; r_x1[i] = x1; r_y1[i] = y1;
   endtask

   task automatic kick();
      @(negedge clk); #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
   endtask

   initial begin
      for (int i = 0; i < NR; i++) set_rect(i, 0, 0, 0, 0, 0);
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;

      // R1 R2 R3 R4: in-place, 32x24, mixed hits and a disabled full-frame rect
      cur_req = "R1/R2/R3/R4";
      inplace = 1; fw = 32; fh = 24; sfmt = 3'd1; ofmt = 3'd1;
      sbase = 32'h1000_0000; obase = 32'h2000_0000;
      set_rect(0, 1, 10, 0, 17, 5);
      set_rect(1, 0, 0, 0, 31, 23);
      set_rect(2, 1, 31, 23, 31, 23);
      kick(); settle();

      // R2: edge bounds, rect touching exactly column 8 and row 7
      cur_req = "R2";
      set_rect(0, 1, 8, 7, 8, 7);
      set_rect(2, 1, 0, 16, 7, 16);
      kick(); settle();

      // R1: no enabled rectangle, whole frame skipped
      cur_req = "R1";
      set_rect(0, 0, 0, 0, 0, 0); set_rect(2, 0, 0, 0, 0, 0);
      kick(); settle();

      // R5: in-place off, partial tiles, overlays ignored
      cur_req = "R5";
      inplace = 0; fw = 20; fh = 10; sfmt = 3'd5; ofmt = 3'd2;
      set_rect(3, 1, 0, 0, 3, 3);
      kick(); settle();

      // R6: YUV source refused
      cur_req = "R6";
      inplace = 1; sfmt = 3'd5; ofmt = 3'd5;
      kick(); settle();

      // R8: valid start clears the flag
      cur_req = "R8";
      sfmt = 3'd2; ofmt = 3'd2;
      kick(); settle();

      // R7: format mismatch, then zero width with in-place off
      cur_req = "R7";
      ofmt = 3'd3;
      kick(); settle();
      inplace = 0; fw = 0;
      kick(); settle();

      // R9: start during a running frame ignored, single done pulse
      cur_req = "R9";
      fw = 16; fh = 16; inplace = 0;
      kick();
      repeat (5) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
      settle();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule